// File: doc/BRIEF.md
# Receive Frame FIFO with Short-Frame Discard

This block is the byte-wide receive buffer between a MAC receiver and a host-side reader. The receiver pushes each frame one byte at a time and marks its first and last bytes. A frame becomes visible to the reader only after its last byte has been stored. A frame that ends below the legal minimum length is removed by moving the write pointer back to where the frame started, so its bytes never reach the reader. Each frame that is kept comes with its byte count and a status word that was captured with its last byte.

The storage holds 3072 bytes by default and is separate from any transmit path. It lets the host side fall behind the line for a while without losing data. If the storage fills while a frame is arriving, that frame is dropped, its bytes are freed, and an overrun counter goes up by one. The same happens when the small queue of frame lengths is already full at the last byte. The reader sees one frame at a time. It takes bytes by pulsing a pop input, and a last-byte flag marks the end of the frame.

Top module: `rx_runt_fifo`

## Requirements
- R1: After reset, rd_frame_avail is 0 and ovr_count is 0.
- R2: A frame of at least MIN_LEN bytes that fits and finds the length queue not full is committed. At the first clock edge after its last byte is accepted, rd_frame_avail is 1. rd_frame_len then equals the frame's byte count, and rd_frame_stat equals the wr_stat value that was presented with that last byte.
- R3: Committed frames are read back in arrival order and their bytes in write order. rd_data shows the current byte while rd_frame_avail is 1. A pop on rd_pop moves to the next byte, and rd_last is 1 exactly on the final byte of the frame.
- R4: A frame whose last byte brings its count below MIN_LEN is dropped without a trace. It never becomes available, ovr_count does not change, and its space is reclaimed for later frames.
- R5: Bytes of a frame still in progress are never visible. rd_frame_avail stays 0 until a frame commits.
- R6: If a byte arrives while all DEPTH bytes of storage are in use (committed plus in-progress), the frame is dropped and ovr_count rises by 1. Its remaining bytes, up to and including its end marker, are ignored. This does not apply when that byte is the end byte of a short frame, which is handled as in R4.
- R7: If a frame that fits ends while LQ_DEPTH committed frames are still unread, it is dropped and ovr_count rises by 1.
- R8: A start marker that arrives before the current frame has ended abandons that frame silently and begins a new one.
- R9: Bytes presented with no frame open and no start marker are ignored. They store nothing and do not change ovr_count.
- R10: rd_pop while rd_frame_avail is 0 has no effect on later read data.
- R11: A frame of exactly MIN_LEN bytes is kept. A frame of MIN_LEN-1 bytes is dropped.
- R12: A frame of exactly DEPTH bytes fits into empty storage. While it is unread, the first byte of any following frame causes an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A receive byte is presented this cycle |
| wr_sof | input | 1 | The byte is the first of a frame |
| wr_eof | input | 1 | The byte is the last of a frame |
| wr_data | input | 8 | Receive byte |
| wr_stat | input | STAT_W | Frame status, taken with the last byte |
| rd_pop | input | 1 | Reader takes the current byte |
| rd_frame_avail | output | 1 | A committed frame is ready for the reader |
| rd_frame_len | output | clog2(DEPTH+1) | Byte count of the frame being read |
| rd_frame_stat | output | STAT_W | Status of the frame being read |
| rd_data | output | 8 | Current byte of the frame being read |
| rd_last | output | 1 | Current byte is the frame's last |
| ovr_count | output | OVR_W | Number of frames dropped for lack of space (wraps) |

## Verification
The bench builds the block with DEPTH=200, MIN_LEN=16, LQ_DEPTH=4 and OVR_W=8. With these values a few random frames fill the storage or the length queue, so overruns, runts and pointer wrap at a depth that is not a power of two all show up within a short run. A small minimum length lets runt and boundary frames appear often, and an 8-bit counter keeps the overrun count small. The same sizes let directed tests fill the storage with one frame of exactly DEPTH bytes, or hit the full point in the middle of a frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RECV = 2'd1,
        WS_DROP = 2'd2
    } wr_state_e;

    // Circular increment for a buffer of arbitrary (not necessarily 2^n) depth
    function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 3072,
    parameter int PTR_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxf_lenq.sv
module rxf_lenq #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } lq_state_t;

    lq_state_t s_q, s_d;
    logic [W-1:0] slot [DEPTH];
    logic do_push, do_pop;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign head  = slot[s_q.rd];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            s_d.wr = AW'(rxf_pkg::wrap_inc(32'(s_q.wr), DEPTH));
        end
        if (do_pop) begin
            s_d.rd = AW'(rxf_pkg::wrap_inc(32'(s_q.rd), DEPTH));
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot[s_q.wr] <= push_data;
        end
    end

endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 3072,
    parameter int MIN_LEN = 64,
    parameter int PTR_W   = 12,
    parameter int LEN_W   = 12,
    parameter int STAT_W  = 4,
    parameter int OVR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic [7:0]        wr_data,
    input  logic [STAT_W-1:0] wr_stat,
    input  logic              rd_take,
    input  logic              lq_full,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              lq_push,
    output logic [LEN_W-1:0]  lq_len,
    output logic [STAT_W-1:0] lq_stat,
    output logic [OVR_W-1:0]  ovr_count
);

    typedef struct packed {
        wr_state_e        st;
        logic [PTR_W-1:0] wr_ptr;   // next free byte
        logic [PTR_W-1:0] sof_ptr;  // first byte of the open frame
        logic [LEN_W-1:0] frm_len;  // bytes stored for the open frame
        logic [LEN_W-1:0] used;     // committed + open bytes
        logic [OVR_W-1:0] ovr;
    } wr_state_t;

    wr_state_t s_q, s_d;

    logic             in_frame, take;
    logic [PTR_W-1:0] prior_ptr, fs_ptr, cur_ptr;
    logic [LEN_W-1:0] prior_used, cur_used, fb, len_new, used_base;

    always_comb begin
        s_d = s_q;

        in_frame   = (s_q.st == WS_RECV);
        // A start marker inside an open frame discards that frame first
        prior_ptr  = in_frame ? s_q.sof_ptr : s_q.wr_ptr;
        prior_used = in_frame ? (s_q.used - s_q.frm_len) : s_q.used;
        fs_ptr     = wr_sof ? prior_ptr  : s_q.sof_ptr;
        fb         = wr_sof ? '0         : s_q.frm_len;
        cur_ptr    = wr_sof ? prior_ptr  : s_q.wr_ptr;
        cur_used   = wr_sof ? prior_used : s_q.used;
        len_new    = fb + LEN_W'(1);

        take      = wr_valid && (wr_sof || in_frame);
        used_base = s_q.used;
        mem_we    = 1'b0;
        lq_push   = 1'b0;

        if (take) begin
            if (wr_eof && (len_new < LEN_W'(MIN_LEN))) begin
                // short frame: rewind silently
                s_d.wr_ptr  = fs_ptr;
                used_base   = cur_used - fb;
                s_d.frm_len = '0;
                s_d.st      = WS_IDLE;
            end else if ((cur_used == LEN_W'(DEPTH)) || (wr_eof && lq_full)) begin
                // no room: rewind and count
                s_d.wr_ptr  = fs_ptr;
                used_base   = cur_used - fb;
                s_d.frm_len = '0;
                s_d.ovr     = s_q.ovr + OVR_W'(1);
                s_d.st      = wr_eof ? WS_IDLE : WS_DROP;
            end else begin
                mem_we     = 1'b1;
                s_d.wr_ptr = PTR_W'(wrap_inc(32'(cur_ptr), DEPTH));
                used_base  = cur_used + LEN_W'(1);
                if (wr_eof) begin
                    lq_push     = 1'b1;
                    s_d.frm_len = '0;
                    s_d.st      = WS_IDLE;
                end else begin
                    s_d.sof_ptr = fs_ptr;
                    s_d.frm_len = len_new;
                    s_d.st      = WS_RECV;
                end
            end
        end else if (wr_valid && wr_eof && (s_q.st == WS_DROP)) begin
            s_d.st = WS_IDLE;
        end

        s_d.used = used_base - LEN_W'(rd_take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: WS_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_waddr = cur_ptr;
    assign mem_wdata = wr_data;
    assign lq_len    = len_new;
    assign lq_stat   = wr_stat;
    assign ovr_count = s_q.ovr;

endmodule

// File: rtl/rxf_rd_ctl.sv
module rxf_rd_ctl #(
    parameter int DEPTH = 3072,
    parameter int PTR_W = 12,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pop,
    input  logic             lq_empty,
    input  logic [LEN_W-1:0] head_len,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             take,
    output logic             lq_pop,
    output logic             last
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [LEN_W-1:0] offset;   // bytes already taken from the head frame
    } rd_state_t;

    rd_state_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        last   = !lq_empty && ((s_q.offset + LEN_W'(1)) == head_len);
        take   = rd_pop && !lq_empty;
        lq_pop = 1'b0;
        if (take) begin
            s_d.ptr = PTR_W'(rxf_pkg::wrap_inc(32'(s_q.ptr), DEPTH));
            if (last) begin
                s_d.offset = '0;
                lq_pop     = 1'b1;
            end else begin
                s_d.offset = s_q.offset + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ptr = s_q.ptr;

endmodule

// File: rtl/rx_runt_fifo.sv
module rx_runt_fifo #(
    parameter int DEPTH    = 3072,
    parameter int MIN_LEN  = 64,
    parameter int LQ_DEPTH = 16,
    parameter int STAT_W   = 4,
    parameter int OVR_W    = 16,
    localparam int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic [7:0]        wr_data,
    input  logic [STAT_W-1:0] wr_stat,
    input  logic              rd_pop,
    output logic              rd_frame_avail,
    output logic [LEN_W-1:0]  rd_frame_len,
    output logic [STAT_W-1:0] rd_frame_stat,
    output logic [7:0]        rd_data,
    output logic              rd_last,
    output logic [OVR_W-1:0]  ovr_count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LQ_W  = LEN_W + STAT_W;

    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr, rd_ptr;
    logic [7:0]       mem_wdata;
    logic             lq_push, lq_pop, lq_full, lq_empty, rd_take;
    logic [LEN_W-1:0] lq_len;
    logic [STAT_W-1:0] lq_stat;
    logic [LQ_W-1:0]  lq_head;

    rxf_wr_ctl #(
        .DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .PTR_W(PTR_W),
        .LEN_W(LEN_W), .STAT_W(STAT_W), .OVR_W(OVR_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_eof(wr_eof),
        .wr_data(wr_data), .wr_stat(wr_stat),
        .rd_take(rd_take), .lq_full(lq_full),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .lq_push(lq_push), .lq_len(lq_len), .lq_stat(lq_stat),
        .ovr_count(ovr_count)
    );

    rxf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_ptr), .rdata(rd_data)
    );

    rxf_lenq #(.DEPTH(LQ_DEPTH), .W(LQ_W)) u_lenq (
        .clk(clk), .rst_n(rst_n),
        .push(lq_push), .push_data({lq_len, lq_stat}),
        .pop(lq_pop), .head(lq_head),
        .full(lq_full), .empty(lq_empty)
    );

    rxf_rd_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_pop(rd_pop), .lq_empty(lq_empty),
        .head_len(lq_head[LQ_W-1:STAT_W]),
        .rd_ptr(rd_ptr), .take(rd_take), .lq_pop(lq_pop), .last(rd_last)
    );

    assign rd_frame_avail = !lq_empty;
    assign rd_frame_len   = lq_head[LQ_W-1:STAT_W];
    assign rd_frame_stat  = lq_head[STAT_W-1:0];

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int DEPTH   = 3072,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 12,
    parameter int OVR_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_eof,
    input logic             rd_pop,
    input logic             rd_frame_avail,
    input logic [LEN_W-1:0] rd_frame_len,
    input logic             rd_last,
    input logic [OVR_W-1:0] ovr_count
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_frame_avail && ovr_count == '0));

    p_len_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_avail |-> (rd_frame_len >= LEN_W'(MIN_LEN)));

    p_len_ceiling_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frame_avail |-> (rd_frame_len <= LEN_W'(DEPTH)));

    p_last_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_frame_avail);

    p_ovr_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_count != $past(ovr_count)) |-> (ovr_count == $past(ovr_count) + OVR_W'(1)));

    p_ovr_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(ovr_count));

    p_commit_needs_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_frame_avail && !(wr_valid && wr_eof)) |=> !rd_frame_avail);

    p_head_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frame_avail && !rd_pop) |=> (rd_frame_avail && $stable(rd_frame_len)));

endmodule

bind rx_runt_fifo rxf_chk #(
    .DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .OVR_W(OVR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_eof(wr_eof),
    .rd_pop(rd_pop), .rd_frame_avail(rd_frame_avail),
    .rd_frame_len(rd_frame_len), .rd_last(rd_last), .ovr_count(ovr_count)
);

// File: tb/test_rx_runt_fifo.sv
`timescale 1ns/1ps
module test_rx_runt_fifo;

    localparam int DEPTH    = 200;
    localparam int MIN_LEN  = 16;
    localparam int LQ_DEPTH = 4;
    localparam int STAT_W   = 4;
    localparam int OVR_W    = 8;
    localparam int LEN_W    = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
    logic [7:0]        wr_data = '0;
    logic [STAT_W-1:0] wr_stat = '0;
    logic              rd_pop = 1'b0;
    logic              rd_frame_avail, rd_last;
    logic [LEN_W-1:0]  rd_frame_len;
    logic [STAT_W-1:0] rd_frame_stat;
    logic [7:0]        rd_data;
    logic [OVR_W-1:0]  ovr_count;

    rx_runt_fifo #(
        .DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .LQ_DEPTH(LQ_DEPTH),
        .STAT_W(STAT_W), .OVR_W(OVR_W)
    ) i_rx_runt_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sof(wr_sof),
        .wr_eof(wr_eof), .wr_data(wr_data), .wr_stat(wr_stat), .rd_pop(rd_pop),
        .rd_frame_avail(rd_frame_avail), .rd_frame_len(rd_frame_len),
        .rd_frame_stat(rd_frame_stat), .rd_data(rd_data), .rd_last(rd_last),
        .ovr_count(ovr_count)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_used = 0, m_ovr = 0, next_id = 1;
    int q_len[$], q_stat[$], q_id[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int id, input int i);
        return 8'((id * 37 + i * 11 + (i >> 3)) ^ 8'hA5);
    endfunction

    // 0 = commit, 1 = silent drop, 2 = overrun
    function automatic int predict(input int len);
        int free = DEPTH - m_used;
        if (free + 1 < len) return 2;
        if (len < MIN_LEN) return 1;
        if (free + 1 == len) return 2;
        if (q_len.size() == LQ_DEPTH) return 2;
        return 0;
    endfunction

    task automatic put(input bit v, input bit s, input bit e, input logic [7:0] d, input int st);
        @(negedge clk);
        wr_valid = v; wr_sof = s; wr_eof = e; wr_data = d; wr_stat = STAT_W'(st);
    endtask

    task automatic send_frame(input int len, input int st, input bit gaps);
        int id = next_id++;
        int res = predict(len);
        bit was_empty = (q_len.size() == 0);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) put(1'b0, 1'b0, 1'b0, 8'h00, 0);
            put(1'b1, i == 0, i == len - 1, pat(id, i), st);
            if (i == len - 1 && was_empty)
                chk(rd_frame_avail == 1'b0, "R5 open frame hidden", int'(rd_frame_avail), 0);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
        if (res == 2) m_ovr++;
        if (res == 0) begin
            q_len.push_back(len); q_stat.push_back(st); q_id.push_back(id);
            m_used += len;
        end
        if (res == 1) chk(ovr_count == OVR_W'(m_ovr), "R4 runt leaves count", int'(ovr_count), m_ovr % 256);
        else if (res == 2) chk(ovr_count == OVR_W'(m_ovr), "R6/R7 overrun count", int'(ovr_count), m_ovr % 256);
        else chk(ovr_count == OVR_W'(m_ovr), "R2 commit count", int'(ovr_count), m_ovr % 256);
        chk(rd_frame_avail == (q_len.size() != 0), "R2/R4 availability", int'(rd_frame_avail), int'(q_len.size() != 0));
    endtask

    task automatic drain_one();
        int len = q_len.pop_front();
        int st  = q_stat.pop_front();
        int id  = q_id.pop_front();
        @(negedge clk);
        chk(rd_frame_avail == 1'b1, "R2 frame ready", int'(rd_frame_avail), 1);
        chk(rd_frame_len == LEN_W'(len), "R2 frame length", int'(rd_frame_len), len);
        chk(rd_frame_stat == STAT_W'(st), "R2 frame status", int'(rd_frame_stat), st);
        for (int i = 0; i < len; i++) begin
            chk(rd_data == pat(id, i), "R3 byte order", int'(rd_data), int'(pat(id, i)));
            chk(rd_last == (i == len - 1), "R3 last flag", int'(rd_last), int'(i == len - 1));
            rd_pop = 1'b1;
            @(negedge clk);
        end
        rd_pop = 1'b0;
        m_used -= len;
    endtask

    task automatic drain_all();
        while (q_len.size() != 0) drain_one();
        @(negedge clk);
        chk(rd_frame_avail == 1'b0, "R3 drained empty", int'(rd_frame_avail), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_frame_avail == 1'b0, "R1 reset avail", int'(rd_frame_avail), 0);
        chk(ovr_count == '0, "R1 reset count", int'(ovr_count), 0);

        // R11 boundary lengths
        send_frame(MIN_LEN, 3, 1'b0);
        send_frame(MIN_LEN - 1, 5, 1'b0);
        chk(q_len.size() == 1, "R11 only full-length kept", q_len.size(), 1);
        drain_all();

        // R8 abandoned frame
        for (int i = 0; i < 10; i++) put(1'b1, i == 0, 1'b0, 8'hEE, 0);
        send_frame(30, 7, 1'b0);
        chk(rd_frame_len == LEN_W'(30), "R8 new frame replaces open one", int'(rd_frame_len), 30);
        drain_all();

        // R9 stray bytes
        for (int i = 0; i < 5; i++) put(1'b1, 1'b0, i == 4, 8'h33, 1);
        put(1'b0, 1'b0, 1'b0, 8'h00, 0);
        @(negedge clk);
        chk(rd_frame_avail == 1'b0, "R9 stray bytes not stored", int'(rd_frame_avail), 0);
        chk(ovr_count == OVR_W'(m_ovr), "R9 stray bytes no count", int'(ovr_count), m_ovr);
        send_frame(20, 2, 1'b1);
        drain_all();

        // R10 pops on empty
        rd_pop = 1'b1;
        repeat (3) @(negedge clk);
        rd_pop = 1'b0;
        chk(rd_frame_avail == 1'b0, "R10 empty pop", int'(rd_frame_avail), 0);
        send_frame(22, 9, 1'b0);
        drain_all();

        // R7 length queue full
        for (int k = 0; k < LQ_DEPTH; k++) send_frame(20, k, 1'b0);
        send_frame(20, 15, 1'b0);
        chk(ovr_count == OVR_W'(1), "R7 queue full overrun", int'(ovr_count), 1);
        drain_all();

        // R12 exact capacity then overrun on first byte
        send_frame(DEPTH, 4, 1'b0);
        chk(rd_frame_len == LEN_W'(DEPTH), "R12 full-size frame", int'(rd_frame_len), DEPTH);
        send_frame(20, 6, 1'b0);
        chk(ovr_count == OVR_W'(2), "R12 no space overrun", int'(ovr_count), 2);
        drain_all();

        // R6 full mid-frame, remaining bytes ignored
        send_frame(DEPTH - 10, 1, 1'b0);
        send_frame(30, 8, 1'b1);
        chk(ovr_count == OVR_W'(3), "R6 mid-frame overrun", int'(ovr_count), 3);
        drain_all();
        send_frame(40, 10, 1'b0);
        drain_all();

        // random mix
        for (int r = 0; r < 60; r++) begin
            int nf = 1 + ($urandom % 4);
            for (int f = 0; f < nf; f++)
                send_frame(1 + ($urandom % 70), $urandom % 16, ($urandom % 2) == 1);
            if (($urandom % 3) != 0) drain_all();
        end
        drain_all();

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule